// File: doc/BRIEF.md
# Sticky Status and Error Register Bank

This block sits between a serial link core and a control processor. It watches a set of level signals from the core and keeps a sticky record of each one, so that a short event between two software reads is not missed. There are two kinds of bit. A status bit watches a signal that should stay high: it reads 1 while the signal has stayed high, and it drops to 0 and stays there if the signal was low for even one cycle. An error bit watches a signal that should stay low: it reads 0 while no error has been seen, and it rises to 1 and stays there once the error was high for one cycle.

Software reads the bank over the read channel of an AXI4-Lite port. A read returns the recorded value and re-arms every bit of that word: status bits go back to 1 and error bits go back to 0. The first read therefore reports history, and a second read reports the level the signal has had since the first one. Re-arming happens when the read data is accepted. An event in that cycle, or one that occurs while the response is stalled, is kept for the next read. The four words are a per-lane status word, a per-lane error word, a mixed receive word and a transmit error word. The write channel only returns OKAY.

Top module: `sticky_reg_bank`

## Requirements
- R1: After reset, word 0x00 reads 0x00FFFFFF, words 0x04 and 0x0C read 0, and word 0x08 reads 0x00000001.
- R2: Status bit k of word 0x00 (from `lane_up_i[k]`) reads 0 if that input was low in any cycle since the last read of the word or since reset.
- R3: Error bit k of word 0x04 (from `lane_fault_i[k]`) reads 1 if that input was high in any cycle since the last read of the word or since reset.
- R4: Accepting read data re-arms the word that was read (status bits to 1, error bits to 0), so a second read shows the level the signal has had since the first read.
- R5: Bits 31:24 of words 0x00 and 0x04 read 0. Bits 31:5 of words 0x08 and 0x0C read 0.
- R6: Word 0x08 holds the sticky-low status of `rx_aligned_i` in bit 0 and the sticky-high errors `rx_fault_i[3:0]` in bits 4:1, with `rx_fault_i[j]` at bit j+1.
- R7: Word 0x0C holds five sticky-high errors, `tx_fault_i[j]` at bit j: bit 4 FIFO1 overflow, bit 3 FIFO1 underflow, bit 2 FIFO2 underflow, bit 1 overflow, bit 0 underflow.
- R8: No event is lost. An event in the accept cycle, or one that arrives after the address was taken but before the data was accepted, shows in the next read. While RVALID is high and RREADY is low, RDATA stays stable.
- R9: A synchronous active-high `rst` puts every bit back to its reset value (status 1, error 0) and ends any read in flight.
- R10: A read of an address outside 0x00, 0x04, 0x08 and 0x0C, or of an address that is not word aligned, returns 0 with RRESP OKAY (2'b00) and changes no recorded bit.
- R11: A write handshake gets BRESP OKAY (2'b00) and changes no recorded bit.
- R12: Only one read is in flight at a time: ARREADY is low while RVALID is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_up_i | input | 24 | Per-lane signals that should stay high, recorded sticky-low |
| lane_fault_i | input | 24 | Per-lane error signals, recorded sticky-high |
| rx_aligned_i | input | 1 | Receive alignment signal, recorded sticky-low |
| rx_fault_i | input | 4 | Receive error signals, recorded sticky-high |
| tx_fault_i | input | 5 | Transmit error signals, recorded sticky-high |
| s_araddr | input | 12 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |

## Verification
The bench uses the default parameters: 24 lanes, four receive error bits, five transmit error bits, a 12-bit address and 32-bit data. With these values the top lane (bit 23) sits right below the zero-filled bits 31:24, so an off-by-one in the zero fill or in the lane vector shows up. The small words leave bits 31:5 to check for zero. Because the register index field is 10 bits wide but only four words exist, reads at 0x10 and at a misaligned address both fall outside the map. The 5-bit mixed word puts a status bit and error bits in one word, so the per-bit type selection gets exercised.

// File: rtl/sticky_pkg.sv
package sticky_pkg;

   // Response code returned on both channels
   localparam logic [1:0] AXI_RESP_OKAY = 2'b00;

   // Word order in the address map; the index is address bits above the byte offset
   typedef enum int {
      WORD_LANE_UP    = 0,
      WORD_LANE_FAULT = 1,
      WORD_RX_MIX     = 2,
      WORD_TX_FAULT   = 3,
      WORD_COUNT      = 4
   } word_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sticky_bit.sv
module sticky_bit #(
   parameter bit IS_STATUS = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic sig,
   input  logic capture,
   input  logic accept,
   output logic held
);

   // Value a bit returns to when re-armed: 1 for sticky-low, 0 for sticky-high
   localparam bit REARM = IS_STATUS;

   logic pend;
   logic held_fold;
   logic pend_fold;

   generate
      if (IS_STATUS) begin : g_status
         assign held_fold = held & sig;
         assign pend_fold = pend & sig;
      end else begin : g_error
         assign held_fold = held | sig;
         assign pend_fold = pend | sig;
      end
   endgenerate

   // held: value software sees; pend: events since the word's snapshot was taken
   always_ff @(posedge clk) begin
      if (rst) begin
         held <= REARM;
         pend <= REARM;
      end else begin
         held <= accept  ? pend_fold : held_fold;
         pend <= capture ? sig       : pend_fold;
      end
   end

   AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (rst)
      (sig != REARM) |=> (held != REARM)); // R3

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      ((held != REARM) && !accept) |=> (held != REARM)); // R2

   AST_REARM_QUIET: assert property (@(posedge clk) disable iff (rst)
      (accept && (pend == REARM) && (sig == REARM)) |=> (held == REARM)); // R4

   AST_RESET_VALUE: assert property (@(posedge clk)
      rst |=> (held == REARM)); // R9

endmodule

// File: rtl/sticky_word.sv
module sticky_word #(
   parameter int          W         = 24,
   parameter logic [W-1:0] STAT_MASK = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] sig_i,
   input  logic         capture,
   input  logic         accept,
   output logic [W-1:0] held_o
);

   generate
      if (W < 1) begin : g_bad_width
         $error("sticky_word: W must be at least 1");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         sticky_bit #(.IS_STATUS(STAT_MASK[i])) u_bit (
            .clk     (clk),
            .rst     (rst),
            .sig     (sig_i[i]),
            .capture (capture),
            .accept  (accept),
            .held    (held_o[i])
         );
      end
   endgenerate

endmodule

// File: rtl/axil_rd_port.sv
module axil_rd_port #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int NREG   = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [ADDR_W-1:0]           araddr,
   input  logic                        arvalid,
   output logic                        arready,
   output logic [DATA_W-1:0]           rdata,
   output logic [1:0]                  rresp,
   output logic                        rvalid,
   input  logic                        rready,
   input  logic [NREG-1:0][DATA_W-1:0] words_i,
   output logic [NREG-1:0]             capture_o,
   output logic [NREG-1:0]             accept_o
);
   import sticky_pkg::*;

   localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int FIELD_W = ADDR_W - 2;

   generate
      if (FIELD_W < IDX_W) begin : g_bad_addr
         $error("axil_rd_port: ADDR_W too small for NREG words");
      end
      if (FIELD_W > 32) begin : g_bad_field
         $error("axil_rd_port: ADDR_W too large");
      end
   endgenerate

   logic [FIELD_W-1:0] field;
   logic [IDX_W-1:0]   idx;
   logic               hit;
   logic               ar_hs;
   logic               r_hs;
   logic               cur_hit;
   logic [IDX_W-1:0]   cur_idx;

   assign field   = araddr[ADDR_W-1:2];
   assign idx     = field[IDX_W-1:0];
   assign hit     = (araddr[1:0] == 2'b00) && (32'(field) < 32'(NREG));
   assign arready = !rvalid;
   assign ar_hs   = arvalid && arready;
   assign r_hs    = rvalid && rready;
   assign rresp   = AXI_RESP_OKAY;

   always_ff @(posedge clk) begin
      if (rst) begin
         rvalid  <= 1'b0;
         rdata   <= '0;
         cur_hit <= 1'b0;
         cur_idx <= '0;
      end else if (ar_hs) begin
         rvalid  <= 1'b1;
         rdata   <= hit ? words_i[idx] : '0;
         cur_hit <= hit;
         cur_idx <= idx;
      end else if (r_hs) begin
         rvalid  <= 1'b0;
      end
   end

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_strobe
         assign capture_o[i] = ar_hs && hit && (idx == IDX_W'(i));
         assign accept_o[i]  = r_hs && cur_hit && (cur_idx == IDX_W'(i));
      end
   endgenerate

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
      rvalid |-> !arready); // R12

   AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
      (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R8

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(accept_o) && $onehot0(capture_o)); // R10

   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (ar_hs && !hit) |=> (rdata == '0)); // R10

endmodule

// File: rtl/axil_wr_okay.sv
module axil_wr_okay (
   input  logic       clk,
   input  logic       rst,
   input  logic       awvalid,
   output logic       awready,
   input  logic       wvalid,
   output logic       wready,
   output logic [1:0] bresp,
   output logic       bvalid,
   input  logic       bready
);
   import sticky_pkg::*;

   logic take;

   // Address and data are taken together, one response at a time
   assign take    = awvalid && wvalid && !bvalid;
   assign awready = take;
   assign wready  = take;
   assign bresp   = AXI_RESP_OKAY;

   always_ff @(posedge clk) begin
      if (rst) begin
         bvalid <= 1'b0;
      end else if (take) begin
         bvalid <= 1'b1;
      end else if (bready) begin
         bvalid <= 1'b0;
      end
   end

   AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
      (bvalid && !bready) |=> bvalid); // R11

   AST_B_NO_DOUBLE: assert property (@(posedge clk) disable iff (rst)
      bvalid |-> !awready); // R11

endmodule

// File: rtl/sticky_reg_bank.sv
module sticky_reg_bank #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int LANES    = 24,
   parameter int RX_ERR_W = 4,
   parameter int TX_ERR_W = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [LANES-1:0]    lane_up_i,
   input  logic [LANES-1:0]    lane_fault_i,
   input  logic                rx_aligned_i,
   input  logic [RX_ERR_W-1:0] rx_fault_i,
   input  logic [TX_ERR_W-1:0] tx_fault_i,
   input  logic [ADDR_W-1:0]   s_araddr,
   input  logic                s_arvalid,
   output logic                s_arready,
   output logic [DATA_W-1:0]   s_rdata,
   output logic [1:0]          s_rresp,
   output logic                s_rvalid,
   input  logic                s_rready,
   input  logic                s_awvalid,
   output logic                s_awready,
   input  logic                s_wvalid,
   output logic                s_wready,
   output logic [1:0]          s_bresp,
   output logic                s_bvalid,
   input  logic                s_bready
);
   import sticky_pkg::*;

   localparam int NREG   = WORD_COUNT;
   localparam int RXM_W  = 1 + RX_ERR_W;
   localparam int USED_W = max3(LANES, RXM_W, TX_ERR_W);

   generate
      if (LANES < 1 || LANES > DATA_W) begin : g_bad_lanes
         $error("sticky_reg_bank: LANES must lie in 1..DATA_W");
      end
      if (RXM_W > DATA_W) begin : g_bad_rx
         $error("sticky_reg_bank: RX_ERR_W too large");
      end
      if (TX_ERR_W < 1 || TX_ERR_W > DATA_W) begin : g_bad_tx
         $error("sticky_reg_bank: TX_ERR_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [NREG-1:0]             capture;
   logic [NREG-1:0]             accept;
   logic [NREG-1:0][DATA_W-1:0] words;
   logic [LANES-1:0]            up_held;
   logic [LANES-1:0]            fault_held;
   logic [RXM_W-1:0]            rxm_held;
   logic [TX_ERR_W-1:0]         tx_held;

   sticky_word #(.W(LANES), .STAT_MASK({LANES{1'b1}})) u_lane_up (
      .clk     (clk),
      .rst     (rst),
      .sig_i   (lane_up_i),
      .capture (capture[WORD_LANE_UP]),
      .accept  (accept[WORD_LANE_UP]),
      .held_o  (up_held)
   );

   sticky_word #(.W(LANES), .STAT_MASK('0)) u_lane_fault (
      .clk     (clk),
      .rst     (rst),
      .sig_i   (lane_fault_i),
      .capture (capture[WORD_LANE_FAULT]),
      .accept  (accept[WORD_LANE_FAULT]),
      .held_o  (fault_held)
   );

   // Bit 0 is the sticky-low alignment status, the rest are sticky-high errors
   sticky_word #(.W(RXM_W), .STAT_MASK(RXM_W'(1))) u_rx_mix (
      .clk     (clk),
      .rst     (rst),
      .sig_i   ({rx_fault_i, rx_aligned_i}),
      .capture (capture[WORD_RX_MIX]),
      .accept  (accept[WORD_RX_MIX]),
      .held_o  (rxm_held)
   );

   sticky_word #(.W(TX_ERR_W), .STAT_MASK('0)) u_tx_fault (
      .clk     (clk),
      .rst     (rst),
      .sig_i   (tx_fault_i),
      .capture (capture[WORD_TX_FAULT]),
      .accept  (accept[WORD_TX_FAULT]),
      .held_o  (tx_held)
   );

   assign words[WORD_LANE_UP]    = DATA_W'(up_held);
   assign words[WORD_LANE_FAULT] = DATA_W'(fault_held);
   assign words[WORD_RX_MIX]     = DATA_W'(rxm_held);
   assign words[WORD_TX_FAULT]   = DATA_W'(tx_held);

   axil_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_rd (
      .clk       (clk),
      .rst       (rst),
      .araddr    (s_araddr),
      .arvalid   (s_arvalid),
      .arready   (s_arready),
      .rdata     (s_rdata),
      .rresp     (s_rresp),
      .rvalid    (s_rvalid),
      .rready    (s_rready),
      .words_i   (words),
      .capture_o (capture),
      .accept_o  (accept)
   );

   axil_wr_okay u_wr (
      .clk     (clk),
      .rst     (rst),
      .awvalid (s_awvalid),
      .awready (s_awready),
      .wvalid  (s_wvalid),
      .wready  (s_wready),
      .bresp   (s_bresp),
      .bvalid  (s_bvalid),
      .bready  (s_bready)
   );

   generate
      if (USED_W < DATA_W) begin : g_zero_chk
         AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
            s_rvalid |-> (s_rdata[DATA_W-1:USED_W] == '0)); // R5
      end
   endgenerate

   AST_NO_WRITE_EFFECT: assert property (@(posedge clk) disable iff (rst)
      (s_awready && !lane_fault_i[0] && !accept[WORD_LANE_FAULT] && !fault_held[0])
      |=> !fault_held[0]); // R11

endmodule

// File: tb/sim_sticky_reg_bank.sv
module sim_sticky_reg_bank;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [23:0] lane_up_i = '1;
   logic [23:0] lane_fault_i = '0;
   logic        rx_aligned_i = 1'b1;
   logic [3:0]  rx_fault_i = '0;
   logic [4:0]  tx_fault_i = '0;
   logic [11:0] s_araddr = '0;
   logic        s_arvalid = 1'b0;
   logic        s_arready;
   logic [31:0] s_rdata;
   logic [1:0]  s_rresp;
   logic        s_rvalid;
   logic        s_rready = 1'b0;
   logic        s_awvalid = 1'b0;
   logic        s_awready;
   logic        s_wvalid = 1'b0;
   logic        s_wready;
   logic [1:0]  s_bresp;
   logic        s_bvalid;
   logic        s_bready = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   sticky_reg_bank u0 (
      .clk(clk), .rst(rst),
      .lane_up_i(lane_up_i), .lane_fault_i(lane_fault_i),
      .rx_aligned_i(rx_aligned_i), .rx_fault_i(rx_fault_i), .tx_fault_i(tx_fault_i),
      .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
      .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_wvalid(s_wvalid),
      .s_wready(s_wready), .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [1:0] r);
      @(negedge clk);
      s_araddr  = a;
      s_arvalid = 1'b1;
      s_rready  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      s_arvalid = 1'b0;
      if (!s_rvalid) begin
         n_err++;
         $display("FAIL R12: no read data, actual=0 expected=1");
      end
      d = s_rdata;
      r = s_rresp;
      @(posedge clk);
      @(negedge clk);
      s_rready = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      logic [1:0]  r;
      rd(a, d, r);
      check(req, d, exp);
   endtask

   task automatic t_reset();
      rd_chk("R1 lane up", 12'h000, 32'h00FF_FFFF);
      rd_chk("R1 lane fault", 12'h004, 32'h0);
      rd_chk("R1 rx mix", 12'h008, 32'h1);
      rd_chk("R1 tx fault", 12'h00C, 32'h0);
   endtask

   task automatic t_status();
      @(negedge clk); lane_up_i[5] = 1'b0;
      @(negedge clk); lane_up_i[5] = 1'b1; lane_up_i[23] = 1'b0;
      @(negedge clk); lane_up_i[23] = 1'b1;
      rd_chk("R2 one-cycle lows", 12'h000, 32'h007F_FFDF);
      rd_chk("R4 rearmed status", 12'h000, 32'h00FF_FFFF);
      @(negedge clk); lane_up_i[0] = 1'b0;
      rd_chk("R2 held low", 12'h000, 32'h00FF_FFFE);
      rd_chk("R4 live low on second read", 12'h000, 32'h00FF_FFFE);
      lane_up_i[0] = 1'b1;
      rd_chk("R8 low in accept cycle kept", 12'h000, 32'h00FF_FFFE);
      rd_chk("R4 back high", 12'h000, 32'h00FF_FFFF);
   endtask

   task automatic t_error();
      @(negedge clk); lane_fault_i[0] = 1'b1; lane_fault_i[12] = 1'b1;
      @(negedge clk); lane_fault_i = '0;
      rd_chk("R3 fault pulses", 12'h004, 32'h0000_1001);
      rd_chk("R4 rearmed fault", 12'h004, 32'h0);
      @(negedge clk); lane_fault_i[23] = 1'b1;
      @(negedge clk); lane_fault_i = '0;
      rd_chk("R5 top lane, zero fill", 12'h004, 32'h0080_0000);
   endtask

   task automatic t_rx_mix();
      @(negedge clk); rx_aligned_i = 1'b0; rx_fault_i[2] = 1'b1;
      @(negedge clk); rx_aligned_i = 1'b1; rx_fault_i = '0;
      rd_chk("R6 aligned low and fault 2", 12'h008, 32'h0000_0008);
      rd_chk("R6 rearmed mix", 12'h008, 32'h1);
      @(negedge clk); rx_fault_i = 4'hF;
      @(negedge clk); rx_fault_i = '0;
      rd_chk("R6 all rx faults", 12'h008, 32'h0000_001F);
   endtask

   task automatic t_tx();
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); tx_fault_i = 5'(1 << k);
         @(negedge clk); tx_fault_i = '0;
         rd_chk($sformatf("R7 tx fault bit %0d", k), 12'h00C, 32'(1 << k));
      end
      rd_chk("R7 tx rearmed", 12'h00C, 32'h0);
   endtask

   task automatic t_stall();
      logic [31:0] first;
      @(negedge clk); lane_fault_i[1] = 1'b1;
      @(negedge clk); lane_fault_i = '0;
      s_araddr = 12'h004; s_arvalid = 1'b1; s_rready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      s_arvalid = 1'b0;
      first = s_rdata;
      check("R8 stalled snapshot", first, 32'h0000_0002);
      lane_fault_i[3] = 1'b1;
      @(negedge clk);
      lane_fault_i = '0;
      repeat (3) @(negedge clk);
      check("R8 rdata stable during stall", s_rdata, first);
      check("R12 arready low while rvalid", {31'd0, s_arready}, 32'h0);
      s_rready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      s_rready = 1'b0;
      rd_chk("R8 event during stall kept", 12'h004, 32'h0000_0008);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      logic [1:0]  r;
      @(negedge clk); lane_fault_i[7] = 1'b1;
      @(negedge clk); lane_fault_i = '0;
      rd(12'h010, d, r);
      check("R10 unmapped data", d, 32'h0);
      check("R10 unmapped resp", {30'd0, r}, 32'h0);
      rd(12'h005, d, r);
      check("R10 misaligned data", d, 32'h0);
      rd_chk("R10 bits untouched", 12'h004, 32'h0000_0080);
   endtask

   task automatic t_write();
      @(negedge clk); lane_fault_i[9] = 1'b1;
      @(negedge clk); lane_fault_i = '0;
      s_awvalid = 1'b1; s_wvalid = 1'b1; s_bready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      s_awvalid = 1'b0; s_wvalid = 1'b0;
      check("R11 bvalid", {31'd0, s_bvalid}, 32'h1);
      check("R11 bresp okay", {30'd0, s_bresp}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      s_bready = 1'b0;
      rd_chk("R11 write leaves bits", 12'h004, 32'h0000_0200);
   endtask

   task automatic t_sync_reset();
      @(negedge clk);
      lane_up_i[4] = 1'b0; lane_fault_i[4] = 1'b1; tx_fault_i = 5'h1F; rx_aligned_i = 1'b0;
      @(negedge clk);
      lane_up_i = '1; lane_fault_i = '0; tx_fault_i = '0; rx_aligned_i = 1'b1;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      rd_chk("R9 lane up after reset", 12'h000, 32'h00FF_FFFF);
      rd_chk("R9 lane fault after reset", 12'h004, 32'h0);
      rd_chk("R9 rx mix after reset", 12'h008, 32'h1);
      rd_chk("R9 tx fault after reset", 12'h00C, 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_status();
      t_error();
      t_rx_mix();
      t_tx();
      t_stall();
      t_unmapped();
      t_write();
      t_sync_reset();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule